// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block gathers a set of level-sensitive interrupt inputs and offers one claimable interrupt to a single processor hart. Each source has a small writable priority and an enable bit. The hart has a priority threshold of its own. The block's interrupt request goes high when some enabled, pending source has a priority above that threshold. The block also reports which source is currently winning. Software takes ownership of an interrupt by reading the claim/complete register. It hands the interrupt back by writing the same ID to that register.

A separate software interrupt bit lets software raise an interrupt line for the hart directly. All access goes through a plain synchronous register port with address, write data, write enable and read enable. Read data appears one cycle after the read enable. Source 0 is reserved: its priority and enable read as zero, and it never raises an interrupt.

Top module: `plic_core`

## Requirements
- R1: After reset, irq_o, irq_id_o and swi_o are 0, and every register reads as 0.
- R2: The priority of source i (PRIO_W bits) is written and read at byte address 4*i. Bits above PRIO_W read as 0. Source 0's priority always reads 0. Read data is returned on reg_rdata_o in the cycle after reg_re_i.
- R3: A high level on src_i[i] sets pending bit i, provided the source is neither pending nor claimed. Pending bits read as a packed word at address 0x1000, with bit i belonging to source i. Writes to that address have no effect.
- R4: Enable bits are read/write as a packed word at address 0x2000, with bit i belonging to source i. Bit 0 always reads 0.
- R5: The threshold (PRIO_W bits) is at address 0x200000. irq_o is 1 only when the winning source's priority is strictly greater than the threshold, so a priority of 0 never interrupts.
- R6: The winner is the pending, enabled source with the highest priority, with ties going to the lowest ID. irq_id_o shows the winner's ID while irq_o is 1, and 0 otherwise.
- R7: A read of address 0x200004 returns the current irq_id_o value. When that value is nonzero, the read also clears the source's pending bit and marks the source claimed.
- R8: A write of a claimed source's ID to 0x200004 ends the claim, after which a high level re-latches pending. A write naming a source that is not claimed has no effect.
- R9: A claimed source does not latch pending again, even when its input stays high.
- R10: Bit 0 of address 0x4000000 drives swi_o: writing 1 sets it and writing 0 clears it.
- R11: A pending source whose enable bit is 0 stays visible in the pending word but never wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level interrupt inputs, bit i is source i |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_we_i | input | 1 | Register write enable |
| reg_re_i | input | 1 | Register read enable (claim side effect) |
| reg_rdata_o | output | DATA_W | Read data, valid the cycle after reg_re_i |
| irq_o | output | 1 | Interrupt request to the hart |
| irq_id_o | output | ID_W | ID of the winning source, 0 when none |
| swi_o | output | 1 | Software interrupt to the hart |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- **Threshold boundary.** It sets the threshold equal to, and then one below, the winner's priority. A `>=` compare would raise the request when the two are equal.
- **Priority ties.** Two sources share the top priority. A scan that favours the higher ID would report the wrong source.
- **Claim masking.** A claimed source's input is held high for several cycles. A gateway that lets it re-latch would show it as pending again and hand out duplicate claims.
- **Completion handling.** A correct completion must let the held-high source latch again. A completion naming an unclaimed source must leave its pending bit alone; a loose gateway would drop that interrupt.
- **Register quirks.** It checks writes to the read-only pending word, the reserved source 0, and a priority of 0.

// File: rtl/plic_core_pkg.sv
package plic_core_pkg;

   // Fixed byte offsets of the register groups
   localparam int unsigned OFS_PEND   = 32'h0000_1000;
   localparam int unsigned OFS_ENABLE = 32'h0000_2000;
   localparam int unsigned OFS_THRESH = 32'h0020_0000;
   localparam int unsigned OFS_CLAIM  = 32'h0020_0004;
   localparam int unsigned OFS_SWI    = 32'h0400_0000;

   // Minimum address width that reaches the software interrupt word
   localparam int unsigned MIN_ADDR_W = 27;

   // Width of the claim/complete field as seen by software
   localparam int unsigned CLAIM_FIELD_W = 8;

endpackage

// File: rtl/plic_core_gateway.sv
// Per-source gateway: latches a level request and tracks claim ownership.
module plic_core_gateway (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic src_i,
   input  logic claim_i,
   input  logic complete_i,
   output logic pend_o,
   output logic claimed_o
);

   logic pend_q, claimed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q    <= 1'b0;
         claimed_q <= 1'b0;
      end else begin
         if (claim_i && pend_q) begin
            pend_q    <= 1'b0;
            claimed_q <= 1'b1;
         end else begin
            if (src_i && !pend_q && !claimed_q) pend_q <= 1'b1;
            if (complete_i && claimed_q) claimed_q <= 1'b0;
         end
      end
   end

   assign pend_o    = pend_q;
   assign claimed_o = claimed_q;

endmodule

// File: rtl/plic_core_select.sv
// Finds the eligible source with the highest priority; lowest ID wins ties.
module plic_core_select #(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 2,
   localparam int ID_W   = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]             elig_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   output logic [ID_W-1:0]                best_id_o,
   output logic [PRIO_W-1:0]              best_prio_o
);

   always_comb begin
      best_id_o   = '0;
      best_prio_o = '0;
      // Scan downwards with >= so the lowest ID is the last to replace a tie
      for (int i = NUM_SRC - 1; i >= 1; i--) begin
         if (elig_i[i] && prio_i[i] != '0 && prio_i[i] >= best_prio_o) begin
            best_id_o   = ID_W'(i);
            best_prio_o = prio_i[i];
         end
      end
   end

endmodule

// File: rtl/plic_core.sv
module plic_core
   import plic_core_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 2,
   parameter int ADDR_W  = 27,
   parameter int DATA_W  = 32,
   localparam int ID_W   = $clog2(NUM_SRC)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   input  logic               reg_we_i,
   input  logic               reg_re_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               irq_o,
   output logic [ID_W-1:0]    irq_id_o,
   output logic               swi_o
);

   // Elaboration-time parameter checks
   if (NUM_SRC < 2 || NUM_SRC > DATA_W) begin : g_bad_num_src
      $error("NUM_SRC must lie in 2..DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
      $error("ADDR_W too small for the register map");
   end
   if (ID_W > CLAIM_FIELD_W) begin : g_bad_id_w
      $error("source IDs do not fit the claim field");
   end
   if (PRIO_W < 1 || PRIO_W > DATA_W) begin : g_bad_prio_w
      $error("PRIO_W out of range");
   end

   localparam logic [ADDR_W-1:0] PRIO_END = ADDR_W'(4 * NUM_SRC);

   // ---------------- address decode ----------------
   logic hit_prio, hit_pend, hit_en, hit_thr, hit_claim, hit_swi;
   logic [ID_W-1:0] prio_idx;

   assign hit_prio  = (reg_addr_i < PRIO_END) && (reg_addr_i[1:0] == 2'b00);
   assign prio_idx  = reg_addr_i[ID_W+1:2];
   assign hit_pend  = reg_addr_i == ADDR_W'(OFS_PEND);
   assign hit_en    = reg_addr_i == ADDR_W'(OFS_ENABLE);
   assign hit_thr   = reg_addr_i == ADDR_W'(OFS_THRESH);
   assign hit_claim = reg_addr_i == ADDR_W'(OFS_CLAIM);
   assign hit_swi   = reg_addr_i == ADDR_W'(OFS_SWI);

   // ---------------- configuration registers ----------------
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
   logic [NUM_SRC-1:0]             en_q;
   logic [PRIO_W-1:0]              thr_q;
   logic                           swi_q;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cfg
      if (i == 0) begin : g_reserved
         assign prio_q[i] = '0;
         assign en_q[i]   = 1'b0;
      end else begin : g_live
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               prio_q[i] <= '0;
               en_q[i]   <= 1'b0;
            end else if (reg_we_i) begin
               if (hit_prio && prio_idx == ID_W'(i)) prio_q[i] <= reg_wdata_i[PRIO_W-1:0];
               if (hit_en) en_q[i] <= reg_wdata_i[i];
            end
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         thr_q <= '0;
         swi_q <= 1'b0;
      end else if (reg_we_i) begin
         if (hit_thr) thr_q <= reg_wdata_i[PRIO_W-1:0];
         if (hit_swi) swi_q <= reg_wdata_i[0];
      end
   end

   // ---------------- gateways ----------------
   logic [NUM_SRC-1:0] pend, claimed, claim_vec, complete_vec;
   logic [ID_W-1:0]    best_id;
   logic [PRIO_W-1:0]  best_prio;
   logic [CLAIM_FIELD_W-1:0] done_id;

   assign done_id = reg_wdata_i[CLAIM_FIELD_W-1:0];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign claim_vec[i]    = reg_re_i && hit_claim && irq_o && (best_id == ID_W'(i));
      assign complete_vec[i] = reg_we_i && hit_claim && (done_id == CLAIM_FIELD_W'(i));
      if (i == 0) begin : g_reserved
         assign pend[i]    = 1'b0;
         assign claimed[i] = 1'b0;
      end else begin : g_gw
         plic_core_gateway u_gw (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .src_i     (src_i[i]),
            .claim_i   (claim_vec[i]),
            .complete_i(complete_vec[i]),
            .pend_o    (pend[i]),
            .claimed_o (claimed[i])
         );
      end
   end

   // ---------------- selection ----------------
   plic_core_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_sel (
      .elig_i     (pend & en_q),
      .prio_i     (prio_q),
      .best_id_o  (best_id),
      .best_prio_o(best_prio)
   );

   assign irq_o    = best_prio > thr_q;
   assign irq_id_o = irq_o ? best_id : '0;
   assign swi_o    = swi_q;

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_mux, rdata_q;

   always_comb begin
      rd_mux = '0;
      if (hit_prio)  rd_mux[PRIO_W-1:0]  = prio_q[prio_idx];
      if (hit_pend)  rd_mux[NUM_SRC-1:0] = pend;
      if (hit_en)    rd_mux[NUM_SRC-1:0] = en_q;
      if (hit_thr)   rd_mux[PRIO_W-1:0]  = thr_q;
      if (hit_claim) rd_mux[ID_W-1:0]    = irq_id_o;
      if (hit_swi)   rd_mux[0]           = swi_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rdata_q <= '0;
      else if (reg_re_i) rdata_q <= rd_mux;
   end

   assign reg_rdata_o = rdata_q;

endmodule

// File: rtl/plic_core_checker.sv
module plic_core_checker #(
   parameter int NUM_SRC = 8,
   parameter int ADDR_W  = 27,
   parameter int DATA_W  = 32,
   localparam int ID_W   = $clog2(NUM_SRC)
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [DATA_W-1:0] reg_wdata_i,
   input logic              reg_we_i,
   input logic              reg_re_i,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic              irq_o,
   input logic [ID_W-1:0]   irq_id_o,
   input logic              swi_o
);

   localparam logic [ADDR_W-1:0] A_CLAIM = ADDR_W'(32'h0020_0004);
   localparam logic [ADDR_W-1:0] A_SWI   = ADDR_W'(32'h0400_0000);

   p_irq_has_id_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> irq_id_o != '0);

   p_id_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_o |-> irq_id_o == '0);

   p_id_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> int'(irq_id_o) < NUM_SRC);

   p_claim_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_re_i && reg_addr_i == A_CLAIM) |=> reg_rdata_o == DATA_W'($past(irq_id_o)));

   p_claim_moves_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_re_i && reg_addr_i == A_CLAIM && irq_o) |=> irq_id_o != $past(irq_id_o));

   p_swi_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == A_SWI) |=> swi_o == $past(reg_wdata_i[0]));

   p_swi_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(reg_we_i && reg_addr_i == A_SWI) |=> $stable(swi_o));

endmodule

bind plic_core plic_core_checker #(
   .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .reg_addr_i (reg_addr_i),
   .reg_wdata_i(reg_wdata_i),
   .reg_we_i   (reg_we_i),
   .reg_re_i   (reg_re_i),
   .reg_rdata_o(reg_rdata_o),
   .irq_o      (irq_o),
   .irq_id_o   (irq_id_o),
   .swi_o      (swi_o)
);

// File: tb/plic_core_tb_top.sv
module plic_core_tb_top;

   localparam int NS = 8;
   localparam int AW = 27;
   localparam int DW = 32;
   localparam int IW = $clog2(NS);

   localparam logic [AW-1:0] A_PEND  = 27'h000_1000;
   localparam logic [AW-1:0] A_EN    = 27'h000_2000;
   localparam logic [AW-1:0] A_THR   = 27'h020_0000;
   localparam logic [AW-1:0] A_CLAIM = 27'h020_0004;
   localparam logic [AW-1:0] A_SWI   = 27'h400_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          we = 1'b0;
   logic          re = 1'b0;
   logic [DW-1:0] rdata;
   logic          irq;
   logic [IW-1:0] irq_id;
   logic          swi;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;   // 50 MHz

   plic_core #(.NUM_SRC(NS), .ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_we_i(we), .reg_re_i(re),
      .reg_rdata_o(rdata), .irq_o(irq), .irq_id_o(irq_id), .swi_o(swi)
   );

   // ---------------- scoreboard ----------------
   logic [DW-1:0] exp_q[$];
   string         tag_q[$];
   logic          rd_seen = 1'b0;

   always @(posedge clk) rd_seen <= re;

   always @(negedge clk) begin
      if (rd_seen) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL scoreboard: read data 0x%0h with nothing expected", rdata);
         end else begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata !== e) begin
               fails++;
               $display("FAIL %s: read got 0x%0h expected 0x%0h", t, rdata, e);
            end
         end
      end
   end

   task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string t);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", t, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
      @(negedge clk);
      addr = a; re = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      re = 1'b0;
   endtask

   task automatic pulse(input int s);
      @(negedge clk);
      src[s] = 1'b1;
      @(negedge clk);
      src[s] = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      summary();
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      idle(3);
      @(negedge clk) rst_n = 1'b1;
      idle(1);

      // R1: reset state
      chk(DW'(irq), 0, "R1 irq after reset");
      chk(DW'(irq_id), 0, "R1 id after reset");
      chk(DW'(swi), 0, "R1 swi after reset");
      rd(27'h4, 0, "R1 prio1 reset");
      rd(A_EN, 0, "R1 enable reset");
      rd(A_CLAIM, 0, "R1 claim empty");

      // R2: priority registers
      wr(27'hC, 32'hFFFF_FFFF);
      rd(27'hC, 3, "R2 prio3 masked width");
      wr(27'h0, 3);
      rd(27'h0, 0, "R2 prio0 reserved");
      wr(27'h14, 2);
      rd(27'h14, 2, "R2 prio5");

      // R4: enables
      wr(A_EN, 32'hFF);
      rd(A_EN, 32'hFE, "R4 enable bit0 reserved");

      // R3: pending latch and read-only
      pulse(3);
      rd(A_PEND, 32'h08, "R3 pending latched");
      wr(A_PEND, 0);
      rd(A_PEND, 32'h08, "R3 pending write ignored");
      chk(DW'(irq), 1, "R5 irq prio3 over thr0");
      chk(DW'(irq_id), 3, "R6 id of only pending");

      // R5: threshold boundary
      wr(A_THR, 3);
      chk(DW'(irq), 0, "R5 equal threshold no irq");
      chk(DW'(irq_id), 0, "R6 id zero without irq");
      wr(A_THR, 2);
      chk(DW'(irq), 1, "R5 threshold one below");
      wr(A_THR, 0);

      // R6: higher priority wins, then tie to lowest id
      pulse(5);
      wr(27'hC, 1);
      chk(DW'(irq_id), 5, "R6 higher priority wins");
      wr(27'h14, 3);
      wr(27'hC, 3);
      chk(DW'(irq_id), 3, "R6 tie lowest id");

      // R11: disabled source still pending, never wins
      wr(A_EN, 32'hF6);
      chk(DW'(irq_id), 5, "R11 disabled source skipped");
      rd(A_PEND, 32'h28, "R11 disabled still pending");
      wr(A_EN, 32'hFE);

      // R7: claims
      rd(A_CLAIM, 3, "R7 claim returns winner");
      rd(A_PEND, 32'h20, "R7 claim clears pending");
      chk(DW'(irq_id), 5, "R7 next winner");
      rd(A_CLAIM, 5, "R7 second claim");
      chk(DW'(irq), 0, "R7 nothing left");
      rd(A_CLAIM, 0, "R7 empty claim");

      // R9: claimed source held high does not re-latch
      @(negedge clk) src[3] = 1'b1;
      idle(4);
      rd(A_PEND, 0, "R9 claimed no relatch");
      chk(DW'(irq), 0, "R9 no irq while claimed");

      // R8: completion re-arms the gateway
      wr(A_CLAIM, 3);
      idle(1);
      chk(DW'(irq_id), 3, "R8 relatch after completion");
      rd(A_PEND, 32'h08, "R8 pending after completion");
      // completion of an unclaimed (pending) source is ignored
      @(negedge clk) src[3] = 1'b0;
      wr(A_CLAIM, 3);
      idle(1);
      rd(A_PEND, 32'h08, "R8 unclaimed completion ignored");
      chk(DW'(irq_id), 3, "R8 unclaimed completion keeps irq");
      // completing source 5 with input low leaves it idle
      wr(A_CLAIM, 5);
      idle(1);
      rd(A_PEND, 32'h08, "R8 completion low input");
      pulse(5);
      rd(A_PEND, 32'h28, "R8 source 5 re-armed");

      // R5: priority 0 never interrupts
      wr(27'hC, 0);
      wr(27'h14, 0);
      chk(DW'(irq), 0, "R5 zero priority silent");

      // R10: software interrupt
      wr(A_SWI, 1);
      chk(DW'(swi), 1, "R10 swi set");
      rd(A_SWI, 1, "R10 swi read");
      wr(A_SWI, 2);
      chk(DW'(swi), 0, "R10 swi cleared by bit0");

      idle(3);
      summary();
      $finish;
   end

endmodule